// File: doc/BRIEF.md
# Edge-Kicked Watchdog Timer

This block watches a processor's heartbeat line. Software toggles the line, and every toggle in either direction restarts a fixed timeout window. If the window runs out with no toggle, the active-low flag `wdo_n` goes low. It stays low until the line toggles again.

The heartbeat level comes in without any clock alignment. It passes through a two-flop synchronizer before edge detection. A separate flag marks the line as three-stated or floating. While that flag is set, or while the reset generator reports reset, the timer is held cleared and idle. After either condition ends, the timer waits for the first real toggle before it starts counting. A supply-low flag forces the output low combinationally and lets it go as soon as the flag clears.

Top module: `wdog_edge_timer`

## Requirements
- R1: A change of `wdi_raw` in either direction (0 to 1 or 1 to 0) is a kick. A kick clears the count and starts a new window. The count is zero after the third rising clock edge following the change: two synchronizer stages plus one count register.
- R2: `wdo_n` goes low TIMEOUT_CYCLES rising edges after the count was cleared by a kick, when no further kick occurs. It is still high one edge earlier. From the change of `wdi_raw`, it is high after TIMEOUT_CYCLES+2 edges and low after TIMEOUT_CYCLES+3 edges.
- R3: After a timeout, `wdo_n` stays low for any number of cycles and returns high only when a kick clears the count, three edges after the input change.
- R4: While `wdi_float` is 1, the count is held at zero and the timer is disarmed, so `wdo_n` is high unless `supply_low` is 1. Toggles of `wdi_raw` during that time are ignored. Releasing `wdi_float` is not itself a kick, so no timeout follows unless a later toggle occurs.
- R5: While `rst_active` is 1, the count is held at zero and the timer is disarmed. After `rst_active` clears, nothing counts until the first kick arrives. Likewise, no timeout ever occurs after `rst_n` release until a first kick.
- R6: `supply_low` = 1 drives `wdo_n` low in the same cycle, with no clock edge involved. When `supply_low` returns to 0, `wdo_n` is high at once unless a timeout is latched.
- R7: A `wdi_raw` pulse only one clock period wide is detected. It counts as two consecutive kicks, and the window starts from the second one.
- R8: The count saturates at TIMEOUT_CYCLES and never exceeds it.
- R9: After `rst_n` is released, `wdo_n` is 1 and the timer is disarmed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wdi_raw | input | 1 | Heartbeat line level, not aligned to clk |
| wdi_float | input | 1 | 1 while the heartbeat line is three-stated or floating |
| rst_active | input | 1 | 1 while the system reset generator holds reset |
| supply_low | input | 1 | 1 while the monitored supply is below threshold |
| wdo_n | output | 1 | Active-low watchdog flag |

## Verification
The bench drives `wdi_raw` on falling clock edges and counts rising edges from there. A kick lands in the count on the third edge. A timeout is therefore due after TIMEOUT_CYCLES+3 edges, and the single-clock pulse shifts the timeout one edge later. Each timeout is sampled on the falling edges one edge before it is due and at the edge it is due, so both an early and a late output are caught. Holds by `wdi_float` and `rst_active` take effect on the next edge and are sampled one falling edge after they are applied. The `supply_low` path has no register, so it is sampled 1 ns after its change, well inside the same clock period.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned CNT_W = 32;
  typedef logic [CNT_W-1:0] wdt_cnt_t;
endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_async};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/wdt_edge.sv
module wdt_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic floating,
  output logic kick
);
  logic prev_q;
  logic prev_d;

  // prev tracks the level every cycle, so the level present when floating
  // ends is already the reference and that release is not seen as an edge.
  always_comb begin
    prev_d = level;
    kick   = !floating && (level ^ prev_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYCLES = 80_000_000
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     hold,
  input  logic     kick,
  output wdt_cnt_t cnt_q,
  output logic     armed_q,
  output logic     expired
);
  localparam wdt_cnt_t TERM = wdt_cnt_t'(TIMEOUT_CYCLES);

  wdt_cnt_t cnt_d;
  logic     armed_d;
  logic     cnt_en;
  logic     at_term;

  always_comb begin
    at_term = (cnt_q == TERM);
    cnt_en  = hold || kick || (armed_q && !at_term);
    armed_d = armed_q;
    cnt_d   = cnt_q;
    if (hold) begin
      armed_d = 1'b0;
      cnt_d   = '0;
    end else if (kick) begin
      armed_d = 1'b1;
      cnt_d   = '0;
    end else if (armed_q && !at_term) begin
      cnt_d   = cnt_q + wdt_cnt_t'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

  assign expired = armed_q && at_term;
endmodule

// File: rtl/wdog_edge_timer.sv
module wdog_edge_timer
  import wdt_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYCLES = 80_000_000,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wdi_raw,
  input  logic wdi_float,
  input  logic rst_active,
  input  logic supply_low,
  output logic wdo_n
);
  logic     wdi_s;
  logic     kick;
  logic     hold;
  logic     expired;
  logic     armed_q;
  wdt_cnt_t cnt_q;

  assign hold = wdi_float || rst_active;

  wdt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (wdi_raw),
    .q_sync  (wdi_s)
  );

  wdt_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .level    (wdi_s),
    .floating (wdi_float),
    .kick     (kick)
  );

  wdt_counter #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold    (hold),
    .kick    (kick),
    .cnt_q   (cnt_q),
    .armed_q (armed_q),
    .expired (expired)
  );

  assign wdo_n = !(expired || supply_low);
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
  import wdt_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYCLES = 80_000_000
) (
  input logic     clk,
  input logic     rst_n,
  input logic     wdi_float,
  input logic     rst_active,
  input logic     supply_low,
  input logic     wdo_n,
  input logic     kick,
  input logic     armed_q,
  input wdt_cnt_t cnt_q
);
  localparam wdt_cnt_t TERM = wdt_cnt_t'(TIMEOUT_CYCLES);

  // R8
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TERM);

  // R1
  kick_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kick && !wdi_float && !rst_active) |=> (cnt_q == '0 && armed_q));

  // R4
  float_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdi_float |=> (cnt_q == '0 && !armed_q));

  // R5
  rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_active |=> (cnt_q == '0 && !armed_q));

  // R6
  supply_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low |-> !wdo_n);

  // R3
  latch_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wdo_n && !supply_low && !kick && !wdi_float && !rst_active) |=> !wdo_n);

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && cnt_q < TERM && !kick && !wdi_float && !rst_active)
      |=> (cnt_q == $past(cnt_q) + wdt_cnt_t'(1)));
endmodule

bind wdog_edge_timer wdt_checker #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wdi_float  (wdi_float),
  .rst_active (rst_active),
  .supply_low (supply_low),
  .wdo_n      (wdo_n),
  .kick       (kick),
  .armed_q    (armed_q),
  .cnt_q      (cnt_q)
);

// File: tb/tb_wdog_edge_timer.sv
`timescale 1ns/1ps
module tb_wdog_edge_timer;
  localparam int T = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wdi_raw = 1'b0;
  logic wdi_float = 1'b0;
  logic rst_active = 1'b0;
  logic supply_low = 1'b0;
  logic wdo_n;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  wdog_edge_timer #(.TIMEOUT_CYCLES(T)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .wdi_raw    (wdi_raw),
    .wdi_float  (wdi_float),
    .rst_active (rst_active),
    .supply_low (supply_low),
    .wdo_n      (wdo_n)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired: actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: wdo_n actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic toggle();
    @(negedge clk);
    wdi_raw = ~wdi_raw;
  endtask

  task automatic t_reset();
    tick(1);
    chk(wdo_n, 1'b1, "R9 reset state");
    tick(3 * T);
    chk(wdo_n, 1'b1, "R5 no count before first kick");
  endtask

  task automatic t_timeout();
    toggle();
    tick(T + 2);
    chk(wdo_n, 1'b1, "R2 one edge before timeout");
    tick(1);
    chk(wdo_n, 1'b0, "R2 timeout due");
    tick(3 * T);
    chk(wdo_n, 1'b0, "R3 R8 latched low");
    toggle();
    tick(2);
    chk(wdo_n, 1'b0, "R3 kick not yet registered");
    tick(1);
    chk(wdo_n, 1'b1, "R1 R3 falling edge releases");
  endtask

  task automatic t_periodic();
    for (int i = 0; i < 10; i++) begin
      toggle();
      tick(T / 2);
      chk(wdo_n, 1'b1, "R1 periodic kicks both edges");
    end
  endtask

  task automatic t_float();
    @(negedge clk);
    wdi_float = 1'b1;
    tick(1);
    chk(wdo_n, 1'b1, "R4 float holds");
    for (int i = 0; i < 5; i++) begin
      toggle();
      tick(T);
      chk(wdo_n, 1'b1, "R4 toggles ignored while floating");
    end
    tick(4);
    wdi_float = 1'b0;
    tick(3 * T);
    chk(wdo_n, 1'b1, "R4 release is not a kick");
    toggle();
    tick(T + 3);
    chk(wdo_n, 1'b0, "R2 timeout after float release");
  endtask

  task automatic t_rst_active();
    @(negedge clk);
    rst_active = 1'b1;
    tick(1);
    chk(wdo_n, 1'b1, "R5 reset clears timeout");
    toggle();
    tick(3 * T);
    chk(wdo_n, 1'b1, "R5 no count during reset");
    rst_active = 1'b0;
    tick(3 * T);
    chk(wdo_n, 1'b1, "R5 idle until kick");
    toggle();
    tick(T + 2);
    chk(wdo_n, 1'b1, "R5 kick before due");
    tick(1);
    chk(wdo_n, 1'b0, "R5 counting after kick");
  endtask

  task automatic t_supply();
    toggle();
    tick(4);
    chk(wdo_n, 1'b1, "R6 high before supply low");
    supply_low = 1'b1;
    #1;
    chk(wdo_n, 1'b0, "R6 immediate low");
    tick(2);
    supply_low = 1'b0;
    #1;
    chk(wdo_n, 1'b1, "R6 immediate release");
  endtask

  task automatic t_pulse();
    @(negedge clk);
    rst_active = 1'b1;
    tick(1);
    rst_active = 1'b0;
    tick(2);
    toggle();
    toggle();
    tick(T + 2);
    chk(wdo_n, 1'b1, "R7 pulse window one edge before");
    tick(1);
    chk(wdo_n, 1'b0, "R7 pulse detected as kick");
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    t_reset();
    t_timeout();
    t_periodic();
    t_float();
    t_rst_active();
    t_supply();
    t_pulse();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule